// File: doc/BRIEF.md
# Key-Sequence Register Write Guard

This block sits between a simple register bus and a bank of configuration registers and decides, write by write, whether a store may land. A dedicated key address takes single bytes. A fixed two-byte sequence written there opens the guard, and any other key byte closes it again. Software opens the guard just before it touches configuration and closes it as soon as it is done. Registers inside a protected address window then accept writes only while the guard is open.

Writes to the key address itself never reach the register file. Writes outside the protected window, such as those to general-purpose storage, always pass. Reads pass through unchanged in every state. A write blocked by the guard is discarded without any error indication.

Top module: `wp_gate`

## Requirements
- R1: After reset the guard is closed, so `locked` reads 1.
- R2: A key write of byte 0xCA followed by a key write of byte 0x53, with no other key write between them, drives `locked` to 0 in the cycle after the second key write.
- R3: After 0xCA alone the guard is still closed: `locked` stays 1 and protected writes are dropped.
- R4: While the first key byte is pending, any key byte other than 0x53 (0xCA included) closes the guard and restarts the sequence, so a 0x53 that follows does not open it.
- R5: Writing byte 0xFF to the key address while open closes the guard in the next cycle.
- R6: Any other key byte written while open (for example 0x53 or 0xCA) also closes the guard.
- R7: A write to a protected address (0x00 to 0x1C) while the guard is closed gives `reg_we` = 0.
- R8: A write to a protected address while the guard is open gives `reg_we` = 1 in the same cycle.
- R9: A write to an address that is neither protected nor the key address (for example 0x50) gives `reg_we` = 1 in every guard state.
- R10: A write to the key address (0x24) never gives `reg_we` = 1.
- R11: `reg_re` follows `bus_re` in the same cycle in every guard state.
- R12: Non-key writes and reads between the two key bytes leave the sequence intact.
- R13: Only bits [7:0] of the write data form the key byte. Upper bits are ignored, so 0x1234_56CA counts as 0xCA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data; bits [7:0] carry the key byte |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| reg_we | output | 1 | Write permit to the register file |
| reg_re | output | 1 | Read strobe to the register file |
| locked | output | 1 | 1 while protected writes are blocked |

## Verification
A sequencer stuck in or skipping the pending state shows up at once. The guard either opens after one byte or stays closed after a correct pair, and `locked` shows this one cycle after the second key write. A wrong restart rule is exposed by the wrong-byte scenarios: a guard that opens on a stray 0x53 after a broken sequence gives `reg_we` = 1 on the very next protected write. Decode faults show in the same cycle as the write, through `reg_we` on key, protected and open addresses.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;

  typedef enum logic [1:0] {
    GS_LOCKED = 2'd0,
    GS_FIRST  = 2'd1,
    GS_OPEN   = 2'd2
  } gate_st_t;

  // next sequencer state for one key write
  function automatic gate_st_t gate_next(gate_st_t cur, logic [7:0] kb,
                                         logic [7:0] k1, logic [7:0] k2);
    gate_st_t nx;
    case (cur)
      GS_LOCKED: nx = (kb == k1) ? GS_FIRST : GS_LOCKED;
      GS_FIRST:  nx = (kb == k2) ? GS_OPEN : GS_LOCKED;
      default:   nx = GS_LOCKED;
    endcase
    return nx;
  endfunction

  function automatic logic in_window(logic [31:0] a, logic [31:0] lo,
                                     logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode #(
  parameter int ADDR_W   = 8,
  parameter int KEY_ADDR = 'h24,
  parameter int PROT_LO  = 'h00,
  parameter int PROT_HI  = 'h1C
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              key_hit,
  output logic              prot_hit
);
  import wp_gate_pkg::*;

  localparam int PAD_W = 32 - ADDR_W;

  logic [31:0] addr_ext;
  assign addr_ext = {{PAD_W{1'b0}}, addr};

  assign key_hit  = (addr_ext == 32'(KEY_ADDR));
  assign prot_hit = in_window(addr_ext, 32'(PROT_LO), 32'(PROT_HI));

  always_comb begin
    a_r10_key_not_prot: assert (!(key_hit && prot_hit))
      else $error("key address overlaps protected window");
  end
endmodule

// File: rtl/wp_key_fsm.sv
module wp_key_fsm #(
  parameter int         DATA_W = 32,
  parameter logic [7:0] KEY1   = 8'hCA,
  parameter logic [7:0] KEY2   = 8'h53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  import wp_gate_pkg::*;

  gate_st_t   st_q;
  gate_st_t   st_d;
  logic [7:0] key_byte;

  assign key_byte = wdata[7:0];   // R13: upper bits ignored

  always_comb begin
    st_d = st_q;
    if (key_wr) st_d = gate_next(st_q, key_byte, KEY1, KEY2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GS_LOCKED;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == GS_OPEN);

  a_r2_open_on_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && st_q == GS_FIRST && key_byte == KEY2) |=> unlocked)
    else $error("pair did not open guard");

  a_r3_one_byte_not_open: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && st_q == GS_LOCKED) |=> !unlocked)
    else $error("single byte opened guard");

  a_r5_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && unlocked) |=> !unlocked)
    else $error("key write while open did not lock");

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(st_q))
    else $error("state moved without key write");
endmodule

// File: rtl/wp_gate.sv
module wp_gate #(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 32,
  parameter int         KEY_ADDR = 'h24,
  parameter int         PROT_LO  = 'h00,
  parameter int         PROT_HI  = 'h1C,
  parameter logic [7:0] KEY1     = 8'hCA,
  parameter logic [7:0] KEY2     = 8'h53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic              reg_we,
  output logic              reg_re,
  output logic              locked
);
  logic key_hit;
  logic prot_hit;
  logic key_wr;
  logic unlocked;

  wp_addr_decode #(
    .ADDR_W  (ADDR_W),
    .KEY_ADDR(KEY_ADDR),
    .PROT_LO (PROT_LO),
    .PROT_HI (PROT_HI)
  ) u_dec (
    .addr    (bus_addr),
    .key_hit (key_hit),
    .prot_hit(prot_hit)
  );

  assign key_wr = bus_we & key_hit;

  wp_key_fsm #(
    .DATA_W(DATA_W),
    .KEY1  (KEY1),
    .KEY2  (KEY2)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (key_wr),
    .wdata   (bus_wdata),
    .unlocked(unlocked)
  );

  assign locked = ~unlocked;
  assign reg_we = bus_we & ~key_hit & (~prot_hit | unlocked);
  assign reg_re = bus_re;

  a_r7_block_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && prot_hit && locked) |-> !reg_we)
    else $error("protected write passed while locked");

  a_r9_open_area: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !prot_hit && !key_hit) |-> reg_we)
    else $error("unprotected write blocked");

  a_r10_key_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |-> !reg_we)
    else $error("key write reached register file");
endmodule

// File: tb/wp_gate_tb.sv
module wp_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic        reg_we, reg_re, locked;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [7:0] KEY = 8'h24;
  localparam logic [7:0] PROT = 8'h08;
  localparam logic [7:0] FREE = 8'h50;

  always #10 clk = ~clk;

  wp_gate u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .reg_we(reg_we), .reg_re(reg_re),
    .locked(locked)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // one write; reg_we checked in its cycle, locked checked on the next one
  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    input logic exp_we, input logic exp_lk, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    #2 chk(reg_we, exp_we, {tag, " reg_we"});
    @(negedge clk);
    bus_we = 1'b0;
    #2 chk(locked, exp_lk, {tag, " locked"});
  endtask

  task automatic t_reset();
    #2 chk(locked, 1'b1, "R1 reset");
    wr(PROT, 32'h1, 1'b0, 1'b1, "R1 R7 locked after reset");
  endtask

  task automatic t_unlock();
    wr(KEY, 32'hCA, 1'b0, 1'b1, "R3 R10 first byte");
    wr(PROT, 32'h2, 1'b0, 1'b1, "R3 protected after one byte");
    wr(KEY, 32'h53, 1'b0, 1'b0, "R2 second byte");
    wr(PROT, 32'h3, 1'b1, 1'b0, "R8 protected open");
    wr(8'h1C, 32'h3, 1'b1, 1'b0, "R8 window top open");
    wr(KEY, 32'hFF, 1'b0, 1'b1, "R5 lock byte");
    wr(PROT, 32'h4, 1'b0, 1'b1, "R7 after relock");
  endtask

  task automatic t_wrong_byte();
    wr(KEY, 32'hCA, 1'b0, 1'b1, "R4 first");
    wr(KEY, 32'h11, 1'b0, 1'b1, "R4 wrong byte");
    wr(KEY, 32'h53, 1'b0, 1'b1, "R4 stray second");
    wr(KEY, 32'hCA, 1'b0, 1'b1, "R4 first again");
    wr(KEY, 32'hCA, 1'b0, 1'b1, "R4 repeated first");
    wr(KEY, 32'h53, 1'b0, 1'b1, "R4 second after repeat");
    wr(PROT, 32'h5, 1'b0, 1'b1, "R4 protected still blocked");
  endtask

  task automatic t_other_relock();
    wr(KEY, 32'hCA, 1'b0, 1'b1, "R6 first");
    wr(KEY, 32'h53, 1'b0, 1'b0, "R6 second");
    wr(KEY, 32'h53, 1'b0, 1'b1, "R6 relock by 0x53");
    wr(KEY, 32'hCA, 1'b0, 1'b1, "R6 first b");
    wr(KEY, 32'h53, 1'b0, 1'b0, "R6 second b");
    wr(KEY, 32'hCA, 1'b0, 1'b1, "R6 relock by 0xCA");
    wr(PROT, 32'h6, 1'b0, 1'b1, "R6 protected blocked");
  endtask

  task automatic t_free_and_read();
    wr(FREE, 32'h7, 1'b1, 1'b1, "R9 free area locked");
    @(negedge clk);
    bus_re = 1'b1; bus_addr = PROT;
    #2 chk(reg_re, 1'b1, "R11 read while locked");
    @(negedge clk);
    bus_re = 1'b0;
    #2 chk(reg_re, 1'b0, "R11 read idle");
    wr(KEY, 32'hCA, 1'b0, 1'b1, "R12 first");
    wr(FREE, 32'h8, 1'b1, 1'b1, "R12 R9 write between keys");
    @(negedge clk);
    bus_re = 1'b1; bus_addr = KEY;
    @(negedge clk);
    bus_re = 1'b0;
    wr(KEY, 32'h53, 1'b0, 1'b0, "R12 sequence survives");
    wr(FREE, 32'h9, 1'b1, 1'b0, "R9 free area open");
    @(negedge clk);
    bus_re = 1'b1;
    #2 chk(reg_re, 1'b1, "R11 read while open");
    @(negedge clk);
    bus_re = 1'b0;
    wr(KEY, 32'hFF, 1'b0, 1'b1, "R5 lock again");
  endtask

  task automatic t_upper_bits();
    wr(KEY, 32'h1234_56CA, 1'b0, 1'b1, "R13 first with upper bits");
    wr(KEY, 32'hFFFF_FF53, 1'b0, 1'b0, "R13 second with upper bits");
    wr(KEY, 32'h0000_00FF, 1'b0, 1'b1, "R13 lock");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unlock();
    t_wrong_byte();
    t_other_relock();
    t_free_and_read();
    t_upper_bits();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule